// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three complementary output pairs, high side and low side for each of three phases, from a single counter. The counter runs up from zero to a programmed half-period value and then back down. Each phase compares the counter against its own duty value. A dead-time stage then holds back the turn-on edge of each output, so that the two switches of a leg are never on together. A synchronization pulse of programmable width marks the moments at which new settings take effect.

Software writes the period, dead time, pulse width and the three duties through a narrow write port into holding registers. None of these writes changes the outputs straight away. The held values move into the working registers only at a reload event. The reload happens at the start of every period, which keeps the patterns symmetric. When double-update mode is selected, it also happens at the period midpoint, so that the two halves of a period can differ. A status output shows which half of the period is in progress.

Top module: `tri_pwm_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, all high-side outputs, `sync_o` and `half_o` are 0. All holding and working registers reset to zero and the mode reset to single update.
- R2: With a working half-period value P of 2 or more, the counter steps 0,1,…,P,P-1,…,1 and repeats, so a full period lasts 2P clocks. P=1 gives a 2-clock period. P=0 holds the counter at 0, and a start event then occurs on every clock.
- R3: Write address map, with data in `wr_data_i`. Address 0 is the half-period (16 bits). Address 1 is the dead time (bits 9:0). Address 2 is the sync width (bits 7:0). Address 3 is the mode: bit 6 set selects double update. Addresses 4, 5 and 6 are the duties of phases A, B and C (16 bits each). Writes to addresses 0–2 and 4–6 land in holding registers only, and the outputs ignore them until the next reload.
- R4: In single update mode, a reload happens only on the start event, which is the counter at 0 while counting up. The sync pulse then rises once every 2P clocks.
- R5: In double update mode, a reload also happens on the midpoint event, which is the counter at or above P while counting up, with P nonzero. The sync pulse then rises every P clocks.
- R6: A reload copies all holding registers into the working set at that clock edge. A write on the same edge is not included. `sync_o` goes high in the following cycle and stays high for W+1 cycles, where W is the sync width being loaded. A new reload restarts the pulse.
- R7: `half_o` is set in the cycle after a midpoint event and cleared in the cycle after a start event. It does this in both modes.
- R8: The ideal high-side level of a phase with duty d is 1 when d≠0 and either d≥P or counter ≥ P−d. A duty of 0 never turns the high side on. A duty of P or more keeps it on.
- R9: Outputs are registered. An output turns on only after its ideal level has held the same value for 2D+1 consecutive cycles, where D is the working dead time, and it turns off at once. With D=0, high and low are exact complements.
- R10: The high and low outputs of any one phase are never 1 together.
- R11: The mode bit is not held back. It takes effect from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| pwm_hi_o | output | 3 | High-side outputs, bit 0 = phase A |
| pwm_lo_o | output | 3 | Low-side outputs, bit 0 = phase A |
| sync_o | output | 1 | Reload synchronization pulse |
| half_o | output | 1 | Second half-period flag |

## Verification
The assertions hold on every clock for the following rules. No leg has both outputs on. A high side never rises while its low side was on, given a nonzero dead time. The counter never counts down through zero. In single mode the working period changes only at a start event. In double mode every flip of the half flag coincides with an active sync pulse. Exact timing is left to the bench's cycle-by-cycle reference model: the pulse widths, the dead-time lengths and the duty compare thresholds. Only the model can show that writes stay invisible until the right event, and how P=0, P=1, an oversized sync width and a dead time longer than the on-time behave.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  localparam int CNT_W     = 16;
  localparam int DT_W      = 10;
  localparam int SW_W      = 8;
  localparam int NUM_PH    = 3;
  localparam int ADDR_W    = 3;
  localparam int MODE_BIT  = 6;

  localparam int ADDR_PER   = 0;
  localparam int ADDR_DT    = 1;
  localparam int ADDR_SW    = 2;
  localparam int ADDR_MODE  = 3;
  localparam int ADDR_DUTY0 = 4;

  typedef struct packed {
    logic [CNT_W-1:0]             period;
    logic [DT_W-1:0]              deadtime;
    logic [SW_W-1:0]              syncw;
    logic [NUM_PH-1:0][CNT_W-1:0] duty;
  } pwm_cfg_t;
endpackage

// File: rtl/tri_pwm_regs.sv
module tri_pwm_regs
  import tri_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              reload_i,
  output pwm_cfg_t          act_o,
  output logic [SW_W-1:0]   sh_sw_o,
  output logic              dbl_o
);
  pwm_cfg_t sh_q, act_q;
  logic     dbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      dbl_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_PER))  sh_q.period   <= wr_data_i;
      if (wr_addr_i == ADDR_W'(ADDR_DT))   sh_q.deadtime <= wr_data_i[DT_W-1:0];
      if (wr_addr_i == ADDR_W'(ADDR_SW))   sh_q.syncw    <= wr_data_i[SW_W-1:0];
      if (wr_addr_i == ADDR_W'(ADDR_MODE)) dbl_q         <= wr_data_i[MODE_BIT];
      for (int i = 0; i < NUM_PH; i++)
        if (wr_addr_i == ADDR_W'(ADDR_DUTY0 + i)) sh_q.duty[i] <= wr_data_i;
    end
  end

  // holding set moves to the working set on reload only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= '0;
    else if (reload_i) act_q <= sh_q;
  end

  assign act_o   = act_q;
  assign sh_sw_o = sh_q.syncw;
  assign dbl_o   = dbl_q;
endmodule

// File: rtl/tri_pwm_timebase.sv
module tri_pwm_timebase
  import tri_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_i,
  input  logic             dbl_i,
  input  logic [SW_W-1:0]  sh_sw_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             reload_o,
  output logic             sync_o,
  output logic             half_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [SW_W-1:0]  scnt_q;
  logic             sync_q, half_q;
  logic             start_evt, top_evt, mid_evt;

  assign start_evt = up_q && (cnt_q == '0);
  assign top_evt   = up_q && (cnt_q >= per_i);
  assign mid_evt   = top_evt && (per_i != '0);
  assign reload_o  = start_evt || (mid_evt && dbl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (top_evt) begin
        // a period of 0 or 1 never counts down
        if (per_i <= CNT_W'(1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= per_i - CNT_W'(1);
          up_q  <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (cnt_q <= CNT_W'(1)) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      scnt_q <= '0;
    end else if (reload_o) begin
      sync_q <= 1'b1;
      scnt_q <= sh_sw_i;
    end else if (sync_q) begin
      if (scnt_q != '0) scnt_q <= scnt_q - SW_W'(1);
      else              sync_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        half_q <= 1'b0;
    else if (mid_evt)   half_q <= 1'b1;
    else if (start_evt) half_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign up_o   = up_q;
  assign sync_o = sync_q;
  assign half_o = half_q;
endmodule

// File: rtl/tri_pwm_phase.sv
module tri_pwm_phase
  import tri_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dt_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int STAB_W = DT_W + 1;

  logic              ideal, ideal_q, full_on;
  logic [STAB_W-1:0] stab_q, stab_n, dt2;
  logic              hi_q, lo_q;

  assign full_on = duty_i >= per_i;
  assign ideal   = (duty_i != '0) && (full_on || (cnt_i >= per_i - duty_i));
  assign dt2     = {dt_i, 1'b0};
  // run length of the ideal level, minus one, saturating
  assign stab_n  = (ideal != ideal_q) ? '0 :
                   (&stab_q)          ? stab_q : stab_q + STAB_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ideal_q <= 1'b0;
      stab_q  <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      ideal_q <= ideal;
      stab_q  <= stab_n;
      hi_q    <= ideal  && (stab_n >= dt2);
      lo_q    <= !ideal && (stab_n >= dt2);
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
  import tri_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [NUM_PH-1:0] pwm_hi_o,
  output logic [NUM_PH-1:0] pwm_lo_o,
  output logic              sync_o,
  output logic              half_o
);
  pwm_cfg_t         act;
  logic [SW_W-1:0]  sh_sw;
  logic             dbl, reload, tb_up;
  logic [CNT_W-1:0] tb_cnt;

  tri_pwm_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .reload_i (reload),
    .act_o    (act),
    .sh_sw_o  (sh_sw),
    .dbl_o    (dbl)
  );

  tri_pwm_timebase u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .per_i   (act.period),
    .dbl_i   (dbl),
    .sh_sw_i (sh_sw),
    .cnt_o   (tb_cnt),
    .up_o    (tb_up),
    .reload_o(reload),
    .sync_o  (sync_o),
    .half_o  (half_o)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    tri_pwm_phase u_ph (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (tb_cnt),
      .per_i (act.period),
      .duty_i(act.duty[g]),
      .dt_i  (act.deadtime),
      .hi_o  (pwm_hi_o[g]),
      .lo_o  (pwm_lo_o[g])
    );
  end
endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk
  import tri_pwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_PH-1:0] hi_i,
  input logic [NUM_PH-1:0] lo_i,
  input logic              sync_i,
  input logic              half_i,
  input logic              dbl_i,
  input logic              up_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  per_i,
  input logic [DT_W-1:0]   dt_i
);
  // R10
  leg_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_i & lo_i) == '0);

  for (genvar g = 0; g < NUM_PH; g++) begin : g_dt
    // R9
    dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(hi_i[g]) && ($past(dt_i) != '0)) |-> !$past(lo_i[g]));
  end

  // R2
  down_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_i |-> (cnt_i != '0));

  // R4
  single_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(dbl_i) && !($past(up_i) && ($past(cnt_i) == '0))) |-> (per_i == $past(per_i)));

  // R7
  half_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((half_i != $past(half_i)) && $past(dbl_i)) |-> sync_i);
endmodule

bind tri_pwm_gen tri_pwm_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .hi_i  (pwm_hi_o),
  .lo_i  (pwm_lo_o),
  .sync_i(sync_o),
  .half_i(half_o),
  .dbl_i (dbl),
  .up_i  (tb_up),
  .cnt_i (tb_cnt),
  .per_i (act.period),
  .dt_i  (act.deadtime)
);

// File: tb/tri_pwm_gen_bench.sv
`timescale 1ns/1ps
module tri_pwm_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  pwm_hi_o, pwm_lo_o;
  logic        sync_o, half_o;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference state
  int m_cnt, m_up, m_half, m_sync, m_scnt, m_dbl;
  int s_per, s_dt, s_sw, a_per, a_dt;
  int s_duty[3], a_duty[3], ph_last[3], ph_run[3], e_hi[3], e_lo[3];
  int last_rise = 0, interval = 0, prev_sync = 0;

  always #2.5 clk_i = ~clk_i;

  tri_pwm_gen u_tri_pwm_gen (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_half = 0; m_sync = 0; m_scnt = 0; m_dbl = 0;
    s_per = 0; s_dt = 0; s_sw = 0; a_per = 0; a_dt = 0;
    for (int i = 0; i < 3; i++) begin
      s_duty[i] = 0; a_duty[i] = 0; ph_last[i] = 0; ph_run[i] = 0;
      e_hi[i] = 0; e_lo[i] = 0;
    end
  endtask

  task automatic model_step();
    int start, mid, rel, id;
    start = m_up && m_cnt == 0;
    mid   = m_up && m_cnt >= a_per && a_per != 0;
    rel   = start || (mid && m_dbl);
    for (int i = 0; i < 3; i++) begin
      id = (a_duty[i] != 0) && (a_duty[i] >= a_per || m_cnt >= a_per - a_duty[i]);
      if (id == ph_last[i]) ph_run[i] = (ph_run[i] < 2047) ? ph_run[i] + 1 : 2047;
      else                  ph_run[i] = 0;
      e_hi[i] = id && ph_run[i] >= 2 * a_dt;
      e_lo[i] = !id && ph_run[i] >= 2 * a_dt;
      ph_last[i] = id;
    end
    if (m_up) begin
      if (m_cnt >= a_per) begin
        if (a_per <= 1) m_cnt = 0;
        else begin m_cnt = a_per - 1; m_up = 0; end
      end else m_cnt++;
    end else if (m_cnt <= 1) begin m_cnt = 0; m_up = 1; end
    else m_cnt--;
    if (mid) m_half = 1; else if (start) m_half = 0;
    if (rel) begin m_sync = 1; m_scnt = s_sw; end
    else if (m_sync) begin
      if (m_scnt != 0) m_scnt--; else m_sync = 0;
    end
    if (rel) begin
      a_per = s_per; a_dt = s_dt;
      for (int i = 0; i < 3; i++) a_duty[i] = s_duty[i];
    end
    if (wr_en_i) begin
      case (wr_addr_i)
        3'd0: s_per = wr_data_i;
        3'd1: s_dt  = wr_data_i & 16'h3FF;
        3'd2: s_sw  = wr_data_i & 16'h0FF;
        3'd3: m_dbl = wr_data_i[6];
        default: if (wr_addr_i >= 3'd4 && wr_addr_i <= 3'd6) s_duty[wr_addr_i - 4] = wr_data_i;
      endcase
    end
  endtask

  task automatic compare();
    int hv, lv;
    hv = e_hi[0] | (e_hi[1] << 1) | (e_hi[2] << 2);
    lv = e_lo[0] | (e_lo[1] << 1) | (e_lo[2] << 2);
    chk(pwm_hi_o == hv, "R8 R9 high side", pwm_hi_o, hv);
    chk(pwm_lo_o == lv, "R9 low side", pwm_lo_o, lv);
    chk(sync_o == m_sync, "R6 sync", sync_o, m_sync);
    chk(half_o == m_half, "R7 half", half_o, m_half);
    chk((pwm_hi_o & pwm_lo_o) == 0, "R10 overlap", pwm_hi_o & pwm_lo_o, 0);
    if (sync_o && !prev_sync) begin interval = cyc - last_rise; last_rise = cyc; end
    prev_sync = sync_o;
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    cyc++;
    @(negedge clk_i);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int addr, int data);
    wr_en_i = 1'b1; wr_addr_i = addr[2:0]; wr_data_i = data[15:0];
    tick();
    wr_en_i = 1'b0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1
    chk(pwm_hi_o == 0, "R1 hi in reset", pwm_hi_o, 0);
    chk(sync_o == 0 && half_o == 0, "R1 sync/half in reset", {sync_o, half_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk(pwm_hi_o == 0, "R1 hi after reset", pwm_hi_o, 0);

    // R3 single mode setup, R8 duty 0 and full on
    wr(0, 20); wr(1, 2); wr(2, 1);
    wr(4, 5); wr(5, 0); wr(6, 25);
    run(120);
    chk(interval == 40, "R2 R4 single period", interval, 40);

    // R3 holding write mid-period stays invisible until reload
    run(7);
    wr(4, 15); wr(0, 24);
    run(100);
    chk(interval == 48, "R2 R4 new period", interval, 48);

    // R11 mode takes effect at once, R5 midpoint reloads
    wr(3, 16'h0040);
    wr(0, 16); wr(5, 4);
    run(10);
    wr(4, 3); wr(6, 12);
    run(150);
    chk(interval == 16, "R5 double interval", interval, 16);

    // R9 zero dead time gives exact complements
    wr(1, 0);
    run(50);
    for (int i = 0; i < 40; i++) begin
      tick();
      chk(pwm_hi_o == ~pwm_lo_o, "R9 zero dead time", pwm_hi_o, ~pwm_lo_o);
    end

    // R2 degenerate periods, R6 oversized sync width
    wr(0, 1); run(30);
    wr(0, 0); run(30);
    wr(0, 20); wr(2, 30); run(80);
    // dead time longer than on-time
    wr(2, 0); wr(1, 15); wr(0, 10); run(80);

    // R11 clearing bit 6 with other bits set, R4 single interval
    wr(3, 16'h00BF);
    wr(1, 1); wr(0, 12);
    run(100);
    chk(interval == 24, "R4 R11 back to single", interval, 24);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule